// File: doc/BRIEF.md
# Dual-Port Memory Collision Arbiter

This block sits between two independent requesters and a 1K x 8 storage array that both of them may read and write in the same cycle. Each side has its own active-low select, a write strobe (low for write, high for read), an active-low output enable, a 10-bit address, write data and read data. When the two sides touch different words, both accesses proceed together. When both are selected on the same word, the arbiter lets one of them through and holds the other off by pulling that side's active-low hold flag.

The winner depends on which event happened first. If the two addresses already matched and the selects then asserted, the side that was selected earlier wins. If both sides were already selected and then their addresses met, the side that was already sitting at that word wins. When both events land in the same clock cycle, the left side wins. The held side's access is dropped, not queued. The hold flag clears as soon as the winner deselects or leaves the word, and the held side then gets through.

The data paths have no valid/ready handshake. The hold flag is the only back-pressure: a requester that sees its hold flag low must keep its address and data steady and retry. Control inputs are sampled on the rising clock edge. Hold flags and read data are combinational from the current inputs and the registered history.

Top module: `dpc_collision_arb`

## Requirements
- R1: A collision exists only when both selects are low and both addresses are equal. Accesses to different words, or with at most one side selected, proceed on both sides with neither hold flag low.
- R2: If the addresses were already equal in the previous cycle and one side was selected then while the other side's select asserts now, the side that was already selected wins.
- R3: If both sides were selected in the previous cycle at different addresses and now share one, the side whose address is unchanged from the previous cycle wins.
- R4: If neither side qualifies as first (for example, both selects assert together on a shared address), the left side wins.
- R5: The losing side's hold flag is 0 and the winner's hold flag is 1. Both hold flags are never 0 together, and both are 1 out of reset.
- R6: A write from a held side does not change the array, and a held side's read is not presented.
- R7: The grant stays with the winner for as long as the collision persists. When the winner deselects or changes address, the loser's hold flag returns to 1 in that same cycle and its access proceeds.
- R8: A side whose select is high never has its hold flag at 0.
- R9: The read-enable output is 1 only when its side is selected, the write strobe is 1 (read), output enable is 0 and the hold flag is 1. Whenever read-enable is 0, the read data bus is all zeros.
- R10: A permitted write stores its data at the rising clock edge. A permitted read returns the word currently stored at its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| left_sel_n | input | 1 | Left select, active low |
| left_wr_n | input | 1 | Left write strobe: 0 write, 1 read |
| left_oe_n | input | 1 | Left output enable, active low |
| left_addr | input | 10 | Left word address |
| left_wdata | input | 8 | Left write data |
| left_rdata | output | 8 | Left read data, zero when disabled |
| left_rd_en | output | 1 | Left read data is driven |
| left_hold_n | output | 1 | Left hold flag, active low |
| right_sel_n | input | 1 | Right select, active low |
| right_wr_n | input | 1 | Right write strobe: 0 write, 1 read |
| right_oe_n | input | 1 | Right output enable, active low |
| right_addr | input | 10 | Right word address |
| right_wdata | input | 8 | Right write data |
| right_rdata | output | 8 | Right read data, zero when disabled |
| right_rd_en | output | 1 | Right read data is driven |
| right_hold_n | output | 1 | Right hold flag, active low |

## Verification
The bench builds each ordering case on purpose. In the select-first case, a design that reads the history wrongly would hold the early side. In the address-first case, a design that ignores the previous address would hand the word to the latecomer. In the same-cycle tie, a wrong design could hold the left side or neither side. Random traffic on a four-word window then keeps collisions starting, persisting and ending. A design that loses the grant in mid-collision would flip the hold flags. A design that lets a held write through would corrupt a word that a later read exposes. A design that forgets to zero a disabled read bus would show stale bytes.

// File: rtl/dpc_pkg.sv
`timescale 1ns/1ps
package dpc_pkg;
  localparam int unsigned DPC_ADDR_W = 10;
  localparam int unsigned DPC_DATA_W = 8;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpc_port_track.sv
`timescale 1ns/1ps
// Per-side history: remembers last cycle's select and address so the
// arbiter can tell which side reached the shared word first.
module dpc_port_track #(
  parameter int unsigned ADDR_W = dpc_pkg::DPC_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel,
  output logic              was_first
);
  logic              sel_q;
  logic [ADDR_W-1:0] addr_q;

  assign sel = ~sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      sel_q  <= sel;
      addr_q <= addr;
    end
  end

  // Already selected at this very word last cycle.
  assign was_first = sel_q && (addr_q == addr);
endmodule

// File: rtl/dpc_arbiter.sv
`timescale 1ns/1ps
module dpc_arbiter #(
  parameter int unsigned ADDR_W = dpc_pkg::DPC_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              r_sel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_first,
  input  logic              r_first,
  output logic              l_hold_n,
  output logic              r_hold_n
);
  import dpc_pkg::*;

  owner_e owner_q;
  owner_e fresh;
  owner_e gnt;
  logic   collide;

  always_comb begin
    collide = l_sel && r_sel && (l_addr == r_addr);
    // New collision: the side already parked on the word wins, left on tie.
    fresh = (r_first && !l_first) ? OWN_RIGHT : OWN_LEFT;
    gnt   = OWN_NONE;
    if (collide) begin
      gnt = (owner_q != OWN_NONE) ? owner_q : fresh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= gnt;
  end

  assign l_hold_n = (gnt != OWN_RIGHT);
  assign r_hold_n = (gnt != OWN_LEFT);
endmodule

// File: rtl/dpc_store.sv
`timescale 1ns/1ps
module dpc_store #(
  parameter int unsigned ADDR_W = dpc_pkg::DPC_ADDR_W,
  parameter int unsigned DATA_W = dpc_pkg::DPC_DATA_W
) (
  input  logic              clk,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] l_q,
  output logic [DATA_W-1:0] r_q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // The arbiter guarantees both write enables never hit one word together.
  always_ff @(posedge clk) begin
    if (l_we) mem[l_addr] <= l_wdata;
    if (r_we) mem[r_addr] <= r_wdata;
  end

  assign l_q = mem[l_addr];
  assign r_q = mem[r_addr];
endmodule

// File: rtl/dpc_collision_arb.sv
`timescale 1ns/1ps
module dpc_collision_arb #(
  parameter int unsigned ADDR_W = dpc_pkg::DPC_ADDR_W,
  parameter int unsigned DATA_W = dpc_pkg::DPC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              left_sel_n,
  input  logic              left_wr_n,
  input  logic              left_oe_n,
  input  logic [ADDR_W-1:0] left_addr,
  input  logic [DATA_W-1:0] left_wdata,
  output logic [DATA_W-1:0] left_rdata,
  output logic              left_rd_en,
  output logic              left_hold_n,
  input  logic              right_sel_n,
  input  logic              right_wr_n,
  input  logic              right_oe_n,
  input  logic [ADDR_W-1:0] right_addr,
  input  logic [DATA_W-1:0] right_wdata,
  output logic [DATA_W-1:0] right_rdata,
  output logic              right_rd_en,
  output logic              right_hold_n
);
  logic              l_sel, r_sel, l_first, r_first;
  logic              l_we, r_we;
  logic [DATA_W-1:0] l_q, r_q;

  dpc_port_track #(.ADDR_W(ADDR_W)) u_trk_l (
    .clk(clk), .rst_n(rst_n), .sel_n(left_sel_n), .addr(left_addr),
    .sel(l_sel), .was_first(l_first)
  );

  dpc_port_track #(.ADDR_W(ADDR_W)) u_trk_r (
    .clk(clk), .rst_n(rst_n), .sel_n(right_sel_n), .addr(right_addr),
    .sel(r_sel), .was_first(r_first)
  );

  dpc_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .r_sel(r_sel), .l_addr(left_addr), .r_addr(right_addr),
    .l_first(l_first), .r_first(r_first),
    .l_hold_n(left_hold_n), .r_hold_n(right_hold_n)
  );

  assign l_we = l_sel && !left_wr_n  && left_hold_n;
  assign r_we = r_sel && !right_wr_n && right_hold_n;

  dpc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk),
    .l_we(l_we), .l_addr(left_addr), .l_wdata(left_wdata),
    .r_we(r_we), .r_addr(right_addr), .r_wdata(right_wdata),
    .l_q(l_q), .r_q(r_q)
  );

  assign left_rd_en  = l_sel && left_wr_n  && !left_oe_n  && left_hold_n;
  assign right_rd_en = r_sel && right_wr_n && !right_oe_n && right_hold_n;
  assign left_rdata  = left_rd_en  ? l_q : '0;
  assign right_rdata = right_rd_en ? r_q : '0;
endmodule

// File: rtl/dpc_arb_checker.sv
`timescale 1ns/1ps
module dpc_arb_checker #(
  parameter int unsigned ADDR_W = dpc_pkg::DPC_ADDR_W,
  parameter int unsigned DATA_W = dpc_pkg::DPC_DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              left_sel_n,
  input logic              left_wr_n,
  input logic              left_oe_n,
  input logic [ADDR_W-1:0] left_addr,
  input logic              left_rd_en,
  input logic [DATA_W-1:0] left_rdata,
  input logic              left_hold_n,
  input logic              right_sel_n,
  input logic [ADDR_W-1:0] right_addr,
  input logic              right_hold_n
);
  p_hold_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!left_hold_n && !right_hold_n));

  p_standby_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (left_sel_n |-> left_hold_n) and (right_sel_n |-> right_hold_n));

  p_no_collision_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (left_sel_n || right_sel_n || left_addr != right_addr)
      |-> (left_hold_n && right_hold_n));

  p_grant_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_hold_n) |=> (left_sel_n || right_sel_n
                        || left_addr != right_addr || !left_hold_n));

  p_grant_kept_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!right_hold_n) |=> (left_sel_n || right_sel_n
                         || left_addr != right_addr || !right_hold_n));

  p_read_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    left_rd_en |-> (!left_sel_n && left_wr_n && !left_oe_n && left_hold_n));

  p_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !left_rd_en |-> (left_rdata == '0));
endmodule

bind dpc_collision_arb dpc_arb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .left_sel_n(left_sel_n), .left_wr_n(left_wr_n), .left_oe_n(left_oe_n),
  .left_addr(left_addr), .left_rd_en(left_rd_en), .left_rdata(left_rdata),
  .left_hold_n(left_hold_n),
  .right_sel_n(right_sel_n), .right_addr(right_addr), .right_hold_n(right_hold_n)
);

// File: tb/test_dpc_collision_arb.sv
`timescale 1ns/1ps
module test_dpc_collision_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lc = 1'b1, lw = 1'b1, lo = 1'b1, rc = 1'b1, rw = 1'b1, ro = 1'b1;
  logic [9:0] la = '0, ra = '0;
  logic [7:0] ld = '0, rd = '0;
  logic [7:0] l_rdata, r_rdata;
  logic       l_rd_en, r_rd_en, l_hold_n, r_hold_n;

  int n_chk = 0;
  int n_bad = 0;

  // bench reference state
  logic [7:0] m_mem [1024];
  logic       m_val [1024];
  logic       m_psl = 1'b0, m_psr = 1'b0;
  logic [9:0] m_pal = '0, m_par = '0;
  int         m_own = 0;

  always #4 clk = ~clk;

  dpc_collision_arb i_dpc_collision_arb (
    .clk(clk), .rst_n(rst_n),
    .left_sel_n(lc), .left_wr_n(lw), .left_oe_n(lo), .left_addr(la),
    .left_wdata(ld), .left_rdata(l_rdata), .left_rd_en(l_rd_en), .left_hold_n(l_hold_n),
    .right_sel_n(rc), .right_wr_n(rw), .right_oe_n(ro), .right_addr(ra),
    .right_wdata(rd), .right_rdata(r_rdata), .right_rd_en(r_rd_en), .right_hold_n(r_hold_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pick_winner(input logic sl, input logic sr, input logic [9:0] a,
                                     input logic [9:0] b);
    logic lf, rf;
    if (!(sl && sr && a == b)) return 0;
    if (m_own != 0) return m_own;
    lf = m_psl && (m_pal == a);
    rf = m_psr && (m_par == b);
    return (rf && !lf) ? 2 : 1;
  endfunction

  // Apply one cycle of stimulus, check outputs mid-cycle, advance the reference.
  task automatic step(input string htag,
                      input logic c0, input logic w0, input logic o0, input logic [9:0] a0,
                      input logic [7:0] d0,
                      input logic c1, input logic w1, input logic o1, input logic [9:0] a1,
                      input logic [7:0] d1);
    int  win;
    logic sl, sr, elh, erh, ele, ere;
    @(negedge clk);
    lc = c0; lw = w0; lo = o0; la = a0; ld = d0;
    rc = c1; rw = w1; ro = o1; ra = a1; rd = d1;
    #2;
    sl = !c0; sr = !c1;
    win = pick_winner(sl, sr, a0, a1);
    elh = (win != 2);
    erh = (win != 1);
    chk({htag, " left hold"},  {7'b0, l_hold_n}, {7'b0, elh});
    chk({htag, " right hold"}, {7'b0, r_hold_n}, {7'b0, erh});
    ele = sl && w0 && !o0 && elh;
    ere = sr && w1 && !o1 && erh;
    chk("R9 left rd_en",  {7'b0, l_rd_en}, {7'b0, ele});
    chk("R9 right rd_en", {7'b0, r_rd_en}, {7'b0, ere});
    if (!ele) chk("R9 left idle bus", l_rdata, 8'h00);
    else if (m_val[a0]) chk("R10 left read", l_rdata, m_mem[a0]);
    if (!ere) chk("R9 right idle bus", r_rdata, 8'h00);
    else if (m_val[a1]) chk("R10 right read", r_rdata, m_mem[a1]);
    m_own = win;
    if (sl && !w0 && elh) begin m_mem[a0] = d0; m_val[a0] = 1'b1; end
    if (sr && !w1 && erh) begin m_mem[a1] = d1; m_val[a1] = 1'b1; end
    m_psl = sl; m_psr = sr; m_pal = a0; m_par = a1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) m_val[i] = 1'b0;
    void'($urandom(32'h5eed_0071));
    #3;
    chk("R5 reset left hold",  {7'b0, l_hold_n}, 8'h01);
    chk("R5 reset right hold", {7'b0, r_hold_n}, 8'h01);
    chk("R9 reset rd_en",      {7'b0, l_rd_en},  8'h00);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: disjoint words written together, then both read back
    step("R1", 0,0,1,10'd40,8'h3C, 0,0,1,10'd41,8'hC3);
    step("R1", 0,1,0,10'd41,8'h00, 0,1,0,10'd40,8'h00);
    chk("R1 left sees right write", l_rdata, 8'hC3);
    chk("R1 right sees left write", r_rdata, 8'h3C);

    // R2: addresses equal, right selected first, left joins
    step("R2", 1,1,1,10'd8,8'h00, 1,1,1,10'd8,8'h00);
    step("R2", 1,1,1,10'd8,8'h00, 0,1,1,10'd8,8'h00);
    step("R2", 0,1,0,10'd8,8'h00, 0,1,1,10'd8,8'h00);
    chk("R2 left held", {7'b0, l_hold_n}, 8'h00);
    chk("R2 right free", {7'b0, r_hold_n}, 8'h01);

    // R3 / R6 / R7: both selected apart, right moves onto left's word
    step("R3", 1,1,1,10'd0,8'h00, 1,1,1,10'd0,8'h00);
    step("R3", 0,0,1,10'd20,8'h11, 0,0,1,10'd21,8'h22);
    step("R3", 0,0,1,10'd20,8'hAA, 0,0,1,10'd20,8'h55);
    chk("R3 right held", {7'b0, r_hold_n}, 8'h00);
    step("R7", 0,1,1,10'd20,8'h00, 0,0,1,10'd20,8'h66);
    chk("R7 grant kept", {7'b0, r_hold_n}, 8'h00);
    step("R7", 0,1,1,10'd21,8'h00, 0,1,0,10'd20,8'h00);
    chk("R7 released on move", {7'b0, r_hold_n}, 8'h01);
    chk("R6 held write dropped", r_rdata, 8'hAA);

    // R4: both select together on one word
    step("R4", 1,1,1,10'd30,8'h00, 1,1,1,10'd30,8'h00);
    step("R4", 0,1,1,10'd30,8'h00, 0,1,0,10'd30,8'h00);
    chk("R4 right held on tie", {7'b0, r_hold_n}, 8'h00);
    chk("R6 held read hidden", {7'b0, r_rd_en}, 8'h00);

    // R8: standby side on the same word is never held
    step("R8", 0,1,1,10'd30,8'h00, 1,1,1,10'd30,8'h00);
    chk("R8 standby free", {7'b0, r_hold_n}, 8'h01);
    step("R8", 1,1,1,10'd30,8'h00, 0,1,1,10'd30,8'h00);
    chk("R8 standby left free", {7'b0, l_hold_n}, 8'h01);

    // seed the random window, then random traffic
    for (int k = 0; k < 4; k++)
      step("R1", 0,0,1,10'(k),8'(k*17), 1,1,1,10'd512,8'h00);
    for (int n = 0; n < 3000; n++) begin
      logic [9:0] na, nb;
      na = ($urandom % 4 == 0) ? la : 10'($urandom % 4);
      nb = ($urandom % 4 == 0) ? ra : 10'($urandom % 4);
      step("R5", ($urandom % 10) < 3, $urandom % 2, $urandom % 4 == 0, na, 8'($urandom),
                 ($urandom % 10) < 3, $urandom % 2, $urandom % 4 == 0, nb, 8'($urandom));
    end
    finish_run();
  end
endmodule